// File: doc/BRIEF.md
# Triggered Channel Scan Sequencer

This block steps a multi-channel converter front end through its input channels. It holds a programmed channel range (a low bound and a high bound) and a channel pointer. It drives the channel select, raises a one-cycle conversion start pulse, and waits for a conversion-done pulse from the converter. Each finished conversion is handed on as a one-cycle sample strobe carrying the result and the channel it came from. That strobe is the feed for a downstream sample FIFO.

A trigger can start either of two kinds of run. In single mode the trigger produces one conversion on the current pointer, and the pointer then moves to the next channel of the range. In scan mode the trigger converts every channel from the low bound up to the high bound back to back. The busy flag covers the whole run: one conversion in single mode, the entire scan in scan mode. The trigger source depends on the automatic-trigger enable. When the enable is clear, a software start strobe triggers a run. When it is set, one of several clock tick sources triggers a run, and a select input picks which one.

Top module: `scan_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `busy`, `conv_start` and `smp_valid` are 0, `chan_sel` is 0, and both range bounds are 0.
- R2: With `auto_trig_en`=0 only `sw_start` triggers a run. With `auto_trig_en`=1 only `clk_tick[trig_src_sel]` triggers a run. Every trigger input that is not selected has no effect.
- R3: A trigger seen at a clock edge while idle sets `busy` and `conv_start` after that edge. `conv_start` lasts exactly one cycle, and `chan_sel` shows the channel being converted.
- R4: In single mode (`scan_en`=0 at the trigger), a run is one conversion on the current pointer. After the edge that sees `conv_done`, `busy` is 0 and the pointer has moved on by one channel.
- R5: In scan mode (`scan_en`=1 at the trigger), the pointer is first set to the low bound, and channels low to high are converted in ascending order. Each next `conv_start` follows in the cycle after the previous `conv_done` edge. `busy` stays 1 without a gap until the edge that sees the last `conv_done`.
- R6: Stepping past the high bound wraps the pointer back to the low bound, in both modes.
- R7: A trigger that arrives while `busy` is 1 is ignored. It starts no conversion, neither during the run nor after it.
- R8: A pulse on `range_wr` while idle loads both bounds and reloads the pointer to the new low bound, visible on `chan_sel` after that edge. A pulse on `range_wr` while busy is ignored.
- R9: When the low bound is greater than the high bound, the range is the single channel at the low bound.
- R10: Each `conv_done` seen while a conversion is outstanding gives one cycle of `smp_valid` after that edge, with `smp_data` equal to `conv_data` and `smp_chan` equal to the converted channel. A `conv_done` at any other time is ignored.
- R11: The mode is captured at the trigger. Changing `scan_en` during a run does not change that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | 1 = scan mode, 0 = single mode (captured at trigger) |
| auto_trig_en | input | 1 | 1 = tick sources trigger, 0 = software strobe triggers |
| trig_src_sel | input | SEL_W | Index of the tick source used when automatic triggering is on |
| sw_start | input | 1 | Software start strobe |
| clk_tick | input | SRC_N | Tick pulses of the clock trigger sources |
| range_wr | input | 1 | Load strobe for the channel range |
| range_lo | input | CH_W | Low channel bound to load |
| range_hi | input | CH_W | High channel bound to load |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_data | input | DATA_W | Converter result, valid with `conv_done` |
| chan_sel | output | CH_W | Channel select (current pointer) |
| conv_start | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | High for the whole conversion or scan |
| smp_valid | output | 1 | One-cycle strobe of a finished sample |
| smp_chan | output | CH_W | Channel of the finished sample |
| smp_data | output | DATA_W | Result of the finished sample |

## Verification
The bench drives inputs on the falling edge and reads outputs on the next falling edge. So any result of an input takes exactly one rising edge. `busy`, `conv_start` and `chan_sel` are read one cycle after the trigger. `smp_valid`, its data and channel, the drop of `busy` or the next scan `conv_start` are read one cycle after `conv_done`. A reloaded pointer is read one cycle after `range_wr`. While waiting for `conv_done`, every cycle also checks that `busy` holds and that no stray start pulse appears. Injected triggers, range writes and mode flips during a run are followed by checks of the next channels converted, so an ignored input would show up as a wrong channel.

// File: rtl/scan_seq_pkg.sv
// Package: shared types of the channel scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_seq_pkg;

    // Run-control states: idle, launching a conversion, waiting for done
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sseq_trig_mux.sv
// Module: picks the active trigger.
// Software strobe when automatic triggering is off, otherwise the tick
// source addressed by the select input. Purely combinational.
// Assumes: trigger inputs are single-cycle pulses in the clk domain.
module sseq_trig_mux #(
    parameter int SRC_N = 2,
    parameter int SEL_W = $clog2(SRC_N)
) (
    input  logic             auto_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             sw_start,
    input  logic [SRC_N-1:0] clk_tick,
    output logic             trig
);

    logic [SRC_N-1:0] sel_hit;

    // one decoded hit per tick source
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign sel_hit[g] = (src_sel == SEL_W'(g)) && clk_tick[g];
    end

    // final trigger choice between the software and the clock path
    always_comb begin
        trig = auto_en ? (|sel_hit) : sw_start;
    end

endmodule

// File: rtl/sseq_chan_ptr.sv
// Module: channel range registers and channel pointer.
// A range load sets both bounds and puts the pointer at the new low bound.
// A restart puts the pointer at the low bound. A step advances the pointer
// and wraps from the effective top to the low bound. A low bound above the
// high bound collapses the range to the single low channel.
// Assumes: load, restart and step are never requested together except that
// load has priority.
module sseq_chan_ptr #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            range_load,
    input  logic [CH_W-1:0] new_lo,
    input  logic [CH_W-1:0] new_hi,
    input  logic            restart,
    input  logic            step,
    output logic [CH_W-1:0] chan,
    output logic            at_top
);

    logic [CH_W-1:0] lo_q;
    logic [CH_W-1:0] hi_q;
    logic [CH_W-1:0] top_ch;

    // effective top of the range (R9: inverted range is the low channel only)
    always_comb begin
        top_ch = (lo_q > hi_q) ? lo_q : hi_q;
        at_top = (chan == top_ch);
    end

    // bounds and pointer update, load first, then restart, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            chan <= '0;
        end else if (range_load) begin
            lo_q <= new_lo;
            hi_q <= new_hi;
            chan <= new_lo;
        end else if (restart) begin
            chan <= lo_q;
        end else if (step) begin
            chan <= at_top ? lo_q : chan + 1'b1;
        end
    end

    // R9: the pointer never leaves the effective range
    a_r9_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (chan >= lo_q) && (chan <= top_ch));

    // R6: stepping from the top lands on the low bound
    a_r6_wrap_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_top && !range_load && !restart) |=> (chan == $past(lo_q)));

    // R8: a range load puts the pointer on the new low bound
    a_r8_reload_low: assert property (@(posedge clk) disable iff (!rst_n)
        range_load |=> (chan == $past(new_lo)));

endmodule

// File: rtl/sseq_ctrl.sv
// Module: run controller.
// Accepts a trigger only when idle and captures the mode. Launches one
// conversion per channel and waits for done. In scan mode it chains
// conversions until the top channel; in single mode it stops after one.
// Assumes: the converter answers each start with exactly one done pulse.
module sseq_ctrl
    import scan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic scan_in,
    input  logic conv_done,
    input  logic at_top,
    output logic busy,
    output logic conv_start,
    output logic restart,
    output logic step,
    output logic capture
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       scan_q;
    logic       accept;

    // decode of control strobes from the present state
    always_comb begin
        accept     = (state_q == ST_IDLE) && trig;
        restart    = accept && scan_in;
        capture    = (state_q == ST_WAIT) && conv_done;
        step       = capture;
        busy       = (state_q != ST_IDLE);
        conv_start = (state_q == ST_LAUNCH);
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (trig) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (conv_done) state_d = (scan_q && !at_top) ? ST_LAUNCH : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and mode capture at accepted trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scan_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) scan_q <= scan_in;
        end
    end

    // R3: every start pulse is one cycle long inside a busy run
    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (!conv_start && busy));

    // R3: a run always begins with a start pulse
    a_r3_busy_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> conv_start);

    // R7: while waiting, nothing but done can cause a new start
    a_r7_wait_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !conv_done) |=> !conv_start);

    // R4: in single mode the run ends with its one done
    a_r4_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !scan_q) |=> !busy);

    // R5: in scan mode a done below the top launches the next channel
    a_r5_scan_chains: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && scan_q && !at_top) |=> (conv_start && busy));

    // R11: the captured mode holds for the whole run
    a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(scan_q));

endmodule

// File: rtl/sseq_capture.sv
// Module: sample hand-off register.
// On each accepted done it registers the result and the converted channel
// and raises a one-cycle valid strobe for the downstream sample FIFO.
// Assumes: capture comes from the run controller, one per conversion.
module sseq_capture #(
    parameter int CH_W   = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CH_W-1:0]   chan,
    output logic              smp_valid,
    output logic [CH_W-1:0]   smp_chan,
    output logic [DATA_W-1:0] smp_data
);

    // register the finished sample and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_chan  <= '0;
            smp_data  <= '0;
        end else begin
            smp_valid <= capture;
            if (capture) begin
                smp_chan <= chan;
                smp_data <= conv_data;
            end
        end
    end

    // R10: no sample without a done pulse on the previous edge
    a_r10_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(conv_done));

    // R10: the strobe is a single cycle per conversion
    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

endmodule

// File: rtl/scan_sequencer.sv
// Module: top of the triggered channel scan sequencer.
// Ties the trigger selector, channel pointer, run controller and sample
// register together. Range writes are accepted only while idle.
// Assumes: synchronous active-low reset; all inputs in the clk domain.
module scan_sequencer #(
    parameter int CH_W   = 4,
    parameter int DATA_W = 16,
    parameter int SRC_N  = 2,
    localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              auto_trig_en,
    input  logic [SEL_W-1:0]  trig_src_sel,
    input  logic              sw_start,
    input  logic [SRC_N-1:0]  clk_tick,
    input  logic              range_wr,
    input  logic [CH_W-1:0]   range_lo,
    input  logic [CH_W-1:0]   range_hi,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [CH_W-1:0]   chan_sel,
    output logic              conv_start,
    output logic              busy,
    output logic              smp_valid,
    output logic [CH_W-1:0]   smp_chan,
    output logic [DATA_W-1:0] smp_data
);

    logic trig;
    logic restart;
    logic step;
    logic capture;
    logic at_top;
    logic range_load;

    // range writes are refused while a run is in progress (R8)
    always_comb begin
        range_load = range_wr && !busy;
    end

    sseq_trig_mux #(
        .SRC_N (SRC_N),
        .SEL_W (SEL_W)
    ) u_trig (
        .auto_en  (auto_trig_en),
        .src_sel  (trig_src_sel),
        .sw_start (sw_start),
        .clk_tick (clk_tick),
        .trig     (trig)
    );

    sseq_chan_ptr #(
        .CH_W (CH_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .range_load (range_load),
        .new_lo     (range_lo),
        .new_hi     (range_hi),
        .restart    (restart),
        .step       (step),
        .chan       (chan_sel),
        .at_top     (at_top)
    );

    sseq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .scan_in    (scan_en),
        .conv_done  (conv_done),
        .at_top     (at_top),
        .busy       (busy),
        .conv_start (conv_start),
        .restart    (restart),
        .step       (step),
        .capture    (capture)
    );

    sseq_capture #(
        .CH_W   (CH_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .chan      (chan_sel),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .smp_data  (smp_data)
    );

    // R8: a range write during a run leaves the channel sequence alone
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && range_wr && !step) |=> $stable(chan_sel));

    // R1: reset leaves the block idle with no strobes
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !conv_start && !smp_valid && chan_sel == '0));

endmodule

// File: tb/tb_scan_sequencer.sv
`timescale 1ns/1ps
module tb_scan_sequencer;

    localparam int CH_W   = 4;
    localparam int DATA_W = 16;
    localparam int SRC_N  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              scan_en;
    logic              auto_trig_en;
    logic [0:0]        trig_src_sel;
    logic              sw_start;
    logic [SRC_N-1:0]  clk_tick;
    logic              range_wr;
    logic [CH_W-1:0]   range_lo;
    logic [CH_W-1:0]   range_hi;
    logic              conv_done;
    logic [DATA_W-1:0] conv_data;
    logic [CH_W-1:0]   chan_sel;
    logic              conv_start;
    logic              busy;
    logic              smp_valid;
    logic [CH_W-1:0]   smp_chan;
    logic [DATA_W-1:0] smp_data;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model of the range and pointer
    int m_lo = 0, m_hi = 0, m_ptr = 0;
    bit tb_auto = 0;
    int tb_sel  = 0;

    always #4 clk = ~clk;

    scan_sequencer #(.CH_W(CH_W), .DATA_W(DATA_W), .SRC_N(SRC_N)) dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .auto_trig_en(auto_trig_en),
        .trig_src_sel(trig_src_sel), .sw_start(sw_start), .clk_tick(clk_tick),
        .range_wr(range_wr), .range_lo(range_lo), .range_hi(range_hi),
        .conv_done(conv_done), .conv_data(conv_data), .chan_sel(chan_sel),
        .conv_start(conv_start), .busy(busy), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_top(input int lo, input int hi);
        return (lo > hi) ? lo : hi;
    endfunction

    function automatic int next_ch(input int ch, input int lo, input int hi);
        return (ch == eff_top(lo, hi)) ? lo : ch + 1;
    endfunction

    // drive the trigger input that the current configuration selects
    task automatic drive_trig(input bit v);
        if (!tb_auto) sw_start = v;
        else clk_tick[tb_sel] = v;
    endtask

    task automatic set_cfg(input bit auto_v, input int sel_v);
        @(negedge clk);
        tb_auto = auto_v; tb_sel = sel_v;
        auto_trig_en = auto_v; trig_src_sel = 1'(sel_v);
    endtask

    task automatic set_range(input int lo, input int hi);
        @(negedge clk);
        range_wr = 1'b1; range_lo = CH_W'(lo); range_hi = CH_W'(hi);
        @(negedge clk);
        range_wr = 1'b0;
        m_lo = lo; m_hi = hi; m_ptr = lo;
        chk("R8 idle range write reloads pointer", chan_sel, lo);
    endtask

    // one run; noise injects a trigger and a range write, flip toggles scan_en
    task automatic burst(input bit scan, input bit noise, input bit flip);
        int ch, nx, lat, d, top;
        bit last;
        top = eff_top(m_lo, m_hi);
        ch  = scan ? m_lo : m_ptr;
        d   = 0;
        @(negedge clk);
        scan_en = scan; drive_trig(1'b1);
        @(negedge clk);
        drive_trig(1'b0);
        chk("R3 start pulse", conv_start, 1);
        chk("R3 busy set", busy, 1);
        chk("R5 R9 first channel", chan_sel, ch);
        forever begin
            lat = $urandom_range(1, 4);
            for (int i = 1; i <= lat; i++) begin
                @(negedge clk);
                drive_trig(1'b0); range_wr = 1'b0;
                chk("R7 busy held while waiting", busy, 1);
                chk("R3 R7 no extra start", conv_start, 0);
                if (i == 1 && noise) begin
                    drive_trig(1'b1); range_wr = 1'b1;
                    range_lo = CH_W'($urandom); range_hi = CH_W'($urandom);
                end
                if (i == 1 && flip) scan_en = !scan;
                if (i == lat) begin
                    d = $urandom_range(0, 65535);
                    conv_done = 1'b1; conv_data = DATA_W'(d);
                end
            end
            @(negedge clk);
            conv_done = 1'b0; drive_trig(1'b0); range_wr = 1'b0;
            chk("R10 sample strobe", smp_valid, 1);
            chk("R10 sample channel", smp_chan, ch);
            chk("R10 sample data", smp_data, d);
            last = !scan || (ch == top);
            nx   = next_ch(ch, m_lo, m_hi);
            if (last) begin
                chk("R4 R5 R11 busy drops at end", busy, 0);
                chk("R4 no start after end", conv_start, 0);
                chk("R6 pointer after run", chan_sel, nx);
                m_ptr = nx;
                break;
            end else begin
                chk("R5 R11 next start chained", conv_start, 1);
                chk("R5 busy continuous", busy, 1);
                chk("R5 R6 R8 next channel", chan_sel, nx);
                ch = nx;
            end
        end
        @(negedge clk);
        chk("R7 no retrigger after run", busy, 0);
        chk("R10 strobe single cycle", smp_valid, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // watchdog: a hung run is one failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; scan_en = 1'b0; auto_trig_en = 1'b0; trig_src_sel = 1'b0;
        sw_start = 1'b0; clk_tick = '0; range_wr = 1'b0; range_lo = '0; range_hi = '0;
        conv_done = 1'b0; conv_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset start", conv_start, 0);
        chk("R1 reset strobe", smp_valid, 0);
        chk("R1 reset channel", chan_sel, 0);
        rst_n = 1'b1;

        // R1: both bounds are 0 after reset, so every run stays on channel 0
        burst(1'b0, 1'b0, 1'b0);
        burst(1'b1, 1'b0, 1'b0);

        // R4 R6: single mode walks 2,3,4 and wraps to 2
        set_range(2, 4);
        repeat (4) burst(1'b0, 1'b0, 1'b0);

        // R5: scan 1..3
        set_range(1, 3);
        burst(1'b1, 1'b0, 1'b0);

        // R9: inverted range is channel 5 alone
        set_range(5, 2);
        burst(1'b1, 1'b0, 1'b0);
        burst(1'b0, 1'b0, 1'b0);
        burst(1'b0, 1'b0, 1'b0);

        // R7 R8: triggers and range writes during a run are ignored
        set_range(6, 10);
        burst(1'b1, 1'b1, 1'b0);
        burst(1'b0, 1'b1, 1'b0);
        burst(1'b0, 1'b1, 1'b0);

        // R11: flipping the mode during a run has no effect
        burst(1'b1, 1'b0, 1'b1);
        burst(1'b0, 1'b0, 1'b1);

        // R10: done while idle is ignored
        @(negedge clk); conv_done = 1'b1; conv_data = 16'hBEEF;
        @(negedge clk); conv_done = 1'b0;
        chk("R10 idle done gives no strobe", smp_valid, 0);
        chk("R10 idle done keeps pointer", chan_sel, m_ptr);
        chk("R10 idle done keeps idle", busy, 0);

        // R2: automatic triggering, source 0 then source 1
        set_cfg(1'b1, 0);
        @(negedge clk); sw_start = 1'b1; clk_tick[1] = 1'b1;
        @(negedge clk); sw_start = 1'b0; clk_tick[1] = 1'b0;
        chk("R2 unselected inputs ignored (src0)", busy, 0);
        chk("R2 unselected inputs no start (src0)", conv_start, 0);
        burst(1'b0, 1'b0, 1'b0);
        set_cfg(1'b1, 1);
        @(negedge clk); sw_start = 1'b1; clk_tick[0] = 1'b1;
        @(negedge clk); sw_start = 1'b0; clk_tick[0] = 1'b0;
        chk("R2 unselected inputs ignored (src1)", busy, 0);
        burst(1'b1, 1'b0, 1'b0);
        set_cfg(1'b0, 0);
        @(negedge clk); clk_tick = '1;
        @(negedge clk); clk_tick = '0;
        chk("R2 ticks ignored in software mode", busy, 0);
        chk("R2 pointer unchanged by ticks", chan_sel, m_ptr);

        // R8: idle range write mid-sequence reloads the low bound
        set_range(3, 9);
        burst(1'b0, 1'b0, 1'b0);
        burst(1'b0, 1'b0, 1'b0);
        set_range(3, 9);

        // random mix with a fixed seed
        void'($urandom(32'd20240611));
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 3) == 0)
                set_range($urandom_range(0, 15), $urandom_range(0, 15));
            if ($urandom_range(0, 4) == 0) begin
                int a;
                a = $urandom_range(0, 2);
                set_cfg(a != 0, (a == 2) ? 1 : 0);
            end
            burst(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 3) == 0));
        end

        finish_run();
    end

endmodule